// File: doc/BRIEF.md
# Storage Command Sequencer

This block turns one user request into the ordered exchange of frame information structures (FISes) that a DMA transfer with a serial storage drive needs. A request names a direction (read or write), a starting 48-bit sector address, a sector count, and an access mode. In sequential mode, one command covers the whole count. In random mode, the count is split into one-sector commands. Each of those commands fetches its own address from the user side.

Outgoing register and data FISes are written dword by dword into a write buffer that the link layer drains. Incoming FISes are popped from a read buffer and classified by their type byte. Data FIS payloads of a read go straight to the user. A DMA Activate releases the next outgoing Data FIS of a write. The device's closing register FIS ends the command. Its status and error bytes are captured, and a sticky done or error flag is raised.

Sector size in dwords and the sector cap per Data FIS are parameters. The defaults are 128 dwords per sector and 16 sectors per FIS, for a 32-bit path.

Top module: `cmd_seq_fsm`

## Requirements
- R1: After reset the block is idle. `busy`, `done` and `err` are low, and no buffer strobe (`wb_wr`, `rb_rd`, `ud_rd`, `rd_valid`, `lba_take`) is active.
- R2: Every command is a 5-dword host-to-device register FIS, written with `wb_last` set on dword 4 only. The dword layouts are:
  - dword 0: `{8'h00, cmd, 8'h80, 8'h27}`, where `cmd` is 8'h35 for a write and 8'h25 for a read.
  - dword 1: `{8'h40, lba[23:0]}`.
  - dword 2: `{8'h00, lba[47:24]}`.
  - dword 3: `{16'h0, count}`.
  - dword 4: zero.
- R3: A write command is not started while `ud_count` is below one sector (SECT_DW dwords). This gate applies again to every command of a random write.
- R4: On each incoming DMA Activate (type byte 8'h39) during a write, the block sends one Data FIS. It is a header dword 32'h00000046 followed by min(remaining, MAX_SECT) × SECT_DW payload dwords, popped in order from the user buffer, with `wb_last` on the final dword only.
- R5: During a read, the payload dwords of an incoming Data FIS (type 8'h46) appear on `rd_data` with `rd_valid`, in arrival order. The header dword is never forwarded.
- R6: In random mode, a request for N sectors is issued as N commands with count 1. The address of each command is sampled from `cmd_lba` in the cycle where `lba_take` pulses. In sequential mode, one command carries the full count.
- R7: A device-to-host register FIS (type 8'h34) loads `dev_status` from bits [23:16] and `dev_error` from bits [31:24] of its first dword.
  - If status bit 0 is set, `err` rises and any remaining commands are dropped.
  - Otherwise, after the last command, `done` rises.
- R8: A request with a count of zero raises `done` one cycle after acceptance, without writing any FIS.
- R9: Incoming FISes of any other type, and DMA Activate during a read, are drained to their last dword with no output effect.
- R10: `busy` is high from acceptance until `done` or `err` rises. A `cmd_start` seen while busy is ignored. `done` and `err` clear when a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Request strobe, taken when idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_random | input | 1 | 1 = one-sector commands with per-command address |
| cmd_lba | input | 48 | Sector address, sampled when `lba_take` is high |
| cmd_count | input | CW | Sector count of the request |
| lba_take | output | 1 | Address on `cmd_lba` is consumed this cycle |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request completed without error (sticky) |
| err | output | 1 | Device reported an error (sticky) |
| dev_status | output | 8 | Last captured device status byte |
| dev_error | output | 8 | Last captured device error byte |
| ud_count | input | UCW | Dwords waiting in the user write-data buffer |
| ud_data | input | 32 | Head dword of the user write-data buffer |
| ud_rd | output | 1 | Pop the user write-data buffer |
| wb_full | input | 1 | Write buffer cannot accept a dword |
| wb_wr | output | 1 | Write `wb_data` into the write buffer |
| wb_data | output | 32 | Outgoing FIS dword |
| wb_last | output | 1 | Final dword of the outgoing FIS |
| rb_empty | input | 1 | Read buffer has no dword |
| rb_data | input | 32 | Head dword of the read buffer |
| rb_last | input | 1 | Head dword ends its FIS |
| rb_rd | output | 1 | Pop the read buffer |
| rd_valid | output | 1 | `rd_data` carries a read payload dword |
| rd_data | output | 32 | Read payload dword |

## Verification
The hardest case to reach is a random write whose second command finds the user buffer short of a sector after the first command has already finished. The block then sits in its issue state with the read and write buffers both idle.

The bench reaches this case by supplying one dword less than a sector, then exactly one sector. It lets the first command complete and watches that no register FIS appears for many cycles. Only then does it supply the second sector.

Device replies include stray DMA Activate and unknown FIS types inside reads, and an error status in the middle of a random sequence. Together these show that the type decode and the abort path do not leak into the output streams.

// File: rtl/sata_cmd_pkg.sv
package sata_cmd_pkg;
   localparam logic [7:0] FIS_H2D  = 8'h27;
   localparam logic [7:0] FIS_D2H  = 8'h34;
   localparam logic [7:0] FIS_ACT  = 8'h39;
   localparam logic [7:0] FIS_DATA = 8'h46;
   localparam logic [7:0] ATA_WR_DMA_EXT = 8'h35;
   localparam logic [7:0] ATA_RD_DMA_EXT = 8'h25;
   localparam int H2D_DWORDS = 5;

   typedef enum logic [2:0] {
      S_IDLE, S_ISSUE, S_H2D, S_WAIT, S_BODY, S_DHDR, S_DPAY
   } seq_st_t;

   typedef enum logic [1:0] {
      K_OTHER, K_D2H, K_ACT, K_DATA
   } fis_kind_t;
endpackage

// File: rtl/cmd_h2d_fmt.sv
module cmd_h2d_fmt
   import sata_cmd_pkg::*;
(
   input  logic        is_write,
   input  logic [47:0] lba,
   input  logic [15:0] cnt,
   input  logic [2:0]  idx,
   output logic [31:0] dw
);
   logic [7:0] opcode;
   assign opcode = is_write ? ATA_WR_DMA_EXT : ATA_RD_DMA_EXT;

   always_comb begin
      case (idx)
         3'd0:    dw = {8'h00, opcode, 8'h80, FIS_H2D};
         3'd1:    dw = {8'h40, lba[23:0]};
         3'd2:    dw = {8'h00, lba[47:24]};
         3'd3:    dw = {16'h0000, cnt};
         default: dw = 32'h0;
      endcase
   end
endmodule

// File: rtl/cmd_rx_class.sv
module cmd_rx_class
   import sata_cmd_pkg::*;
(
   input  logic [31:0] hdr,
   output fis_kind_t   kind,
   output logic [7:0]  stat,
   output logic [7:0]  errb
);
   always_comb begin
      case (hdr[7:0])
         FIS_D2H:  kind = K_D2H;
         FIS_ACT:  kind = K_ACT;
         FIS_DATA: kind = K_DATA;
         default:  kind = K_OTHER;
      endcase
   end
   assign stat = hdr[23:16];
   assign errb = hdr[31:24];
endmodule

// File: rtl/cmd_burst_calc.sv
module cmd_burst_calc #(
   parameter int SECT_DW  = 128,
   parameter int MAX_SECT = 16,
   parameter int CW       = 16,
   localparam int BW      = $clog2(MAX_SECT * SECT_DW + 1)
) (
   input  logic [CW-1:0] left,
   output logic [CW-1:0] sects,
   output logic [BW-1:0] last_beat
);
   logic [BW-1:0] total;

   assign sects = (left > CW'(MAX_SECT)) ? CW'(MAX_SECT) : left;

   generate
      if ((SECT_DW & (SECT_DW - 1)) == 0) begin : g_shift
         localparam int SH = $clog2(SECT_DW);
         assign total = BW'(sects) << SH;
      end else begin : g_mult
         assign total = BW'(sects) * BW'(SECT_DW);
      end
   endgenerate

   assign last_beat = total - BW'(1);
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
   import sata_cmd_pkg::*;
#(
   parameter int SECT_DW  = 128,
   parameter int MAX_SECT = 16,
   parameter int CW       = 16,
   parameter int UCW      = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_start,
   input  logic           cmd_write,
   input  logic           cmd_random,
   input  logic [47:0]    cmd_lba,
   input  logic [CW-1:0]  cmd_count,
   output logic           lba_take,
   output logic           busy,
   output logic           done,
   output logic           err,
   output logic [7:0]     dev_status,
   output logic [7:0]     dev_error,
   input  logic [UCW-1:0] ud_count,
   input  logic [31:0]    ud_data,
   output logic           ud_rd,
   input  logic           wb_full,
   output logic           wb_wr,
   output logic [31:0]    wb_data,
   output logic           wb_last,
   input  logic           rb_empty,
   input  logic [31:0]    rb_data,
   input  logic           rb_last,
   output logic           rb_rd,
   output logic           rd_valid,
   output logic [31:0]    rd_data
);
   localparam int BW = $clog2(MAX_SECT * SECT_DW + 1);

   generate
      if (SECT_DW < 1 || MAX_SECT < 1) begin : g_bad_size
         $error("SECT_DW and MAX_SECT must be at least 1");
      end
      if (CW < 1 || CW > 16) begin : g_bad_cw
         $error("CW must lie in 1..16 to fit the command count field");
      end
      if (SECT_DW >= (1 << UCW)) begin : g_bad_ucw
         $error("UCW too narrow to express one sector of dwords");
      end
   endgenerate

   seq_st_t       st;
   fis_kind_t     kind_q, hdr_kind, cur_kind;
   logic          op_write, op_random;
   logic [CW-1:0] cnt_q, ops_left, op_cnt, sect_left, burst_sects;
   logic [47:0]   op_lba;
   logic [2:0]    idx;
   logic [BW-1:0] beat, last_beat;
   logic [7:0]    status_q, error_q, hdr_stat, hdr_errb;
   logic [31:0]   h2d_dw;
   logic          gate_ok, h2d_fire, dhdr_fire, pay_fire, cur_err;

   cmd_h2d_fmt u_fmt (
      .is_write(op_write), .lba(op_lba), .cnt(16'(op_cnt)), .idx(idx), .dw(h2d_dw)
   );

   cmd_rx_class u_cls (
      .hdr(rb_data), .kind(hdr_kind), .stat(hdr_stat), .errb(hdr_errb)
   );

   cmd_burst_calc #(.SECT_DW(SECT_DW), .MAX_SECT(MAX_SECT), .CW(CW)) u_burst (
      .left(sect_left), .sects(burst_sects), .last_beat(last_beat)
   );

   assign gate_ok   = !op_write || (ud_count >= UCW'(SECT_DW));
   assign lba_take  = (st == S_ISSUE) && gate_ok;
   assign h2d_fire  = (st == S_H2D) && !wb_full;
   assign dhdr_fire = (st == S_DHDR) && !wb_full;
   assign pay_fire  = (st == S_DPAY) && !wb_full && (ud_count != '0);
   assign rb_rd     = ((st == S_WAIT) || (st == S_BODY)) && !rb_empty;
   assign cur_kind  = (st == S_WAIT) ? hdr_kind : kind_q;
   assign cur_err   = (st == S_WAIT) ? hdr_stat[0] : status_q[0];
   assign rd_valid  = (st == S_BODY) && rb_rd && (kind_q == K_DATA) && !op_write;
   assign rd_data   = rb_data;
   assign ud_rd     = pay_fire;
   assign wb_wr     = h2d_fire || dhdr_fire || pay_fire;
   assign wb_data   = h2d_fire ? h2d_dw : (dhdr_fire ? {24'h0, FIS_DATA} : ud_data);
   assign wb_last   = (h2d_fire && idx == 3'(H2D_DWORDS - 1)) ||
                      (pay_fire && beat == last_beat);
   assign busy       = (st != S_IDLE);
   assign dev_status = status_q;
   assign dev_error  = error_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         kind_q    <= K_OTHER;
         op_write  <= 1'b0;
         op_random <= 1'b0;
         cnt_q     <= '0;
         ops_left  <= '0;
         op_cnt    <= '0;
         sect_left <= '0;
         op_lba    <= '0;
         idx       <= '0;
         beat      <= '0;
         status_q  <= '0;
         error_q   <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
      end else begin
         case (st)
            S_IDLE: if (cmd_start) begin
               op_write  <= cmd_write;
               op_random <= cmd_random;
               cnt_q     <= cmd_count;
               ops_left  <= cmd_random ? cmd_count : CW'(1);
               err       <= 1'b0;
               done      <= (cmd_count == '0);
               if (cmd_count != '0) st <= S_ISSUE;
            end
            S_ISSUE: if (gate_ok) begin
               op_lba    <= cmd_lba;
               op_cnt    <= op_random ? CW'(1) : cnt_q;
               sect_left <= op_random ? CW'(1) : cnt_q;
               idx       <= '0;
               st        <= S_H2D;
            end
            S_H2D: if (h2d_fire) begin
               if (idx == 3'(H2D_DWORDS - 1)) st <= S_WAIT;
               else idx <= idx + 3'd1;
            end
            S_WAIT, S_BODY: if (rb_rd) begin
               if (st == S_WAIT) begin
                  kind_q <= hdr_kind;
                  if (hdr_kind == K_D2H) begin
                     status_q <= hdr_stat;
                     error_q  <= hdr_errb;
                  end
               end
               if (rb_last) begin
                  case (cur_kind)
                     K_D2H: begin
                        if (cur_err) begin
                           err <= 1'b1;
                           st  <= S_IDLE;
                        end else if (ops_left == CW'(1)) begin
                           done <= 1'b1;
                           st   <= S_IDLE;
                        end else begin
                           ops_left <= ops_left - CW'(1);
                           st       <= S_ISSUE;
                        end
                     end
                     K_ACT:   st <= (op_write && sect_left != '0) ? S_DHDR : S_WAIT;
                     default: st <= S_WAIT;
                  endcase
               end else if (st == S_WAIT) begin
                  st <= S_BODY;
               end
            end
            S_DHDR: if (dhdr_fire) begin
               beat <= '0;
               st   <= S_DPAY;
            end
            S_DPAY: if (pay_fire) begin
               if (beat == last_beat) begin
                  sect_left <= sect_left - burst_sects;
                  st        <= S_WAIT;
               end else begin
                  beat <= beat + BW'(1);
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R3: a write command waits in the issue state while less than a sector is buffered
   assert_write_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_ISSUE && op_write && ud_count < UCW'(SECT_DW)) |=> (st == S_ISSUE));

   assert_pop_with_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ud_rd |-> (wb_wr && !wb_full && ud_count != '0));

   assert_beat_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DPAY) |-> (beat <= last_beat));

   assert_no_read_out_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !op_write);

   assert_ops_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (ops_left != '0));

   assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   assert_idle_on_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |-> !busy);
endmodule

// File: tb/sim_cmd_seq_fsm.sv
module sim_cmd_seq_fsm;
   localparam int SD = 4;
   localparam int MS = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0, cmd_write = 1'b0, cmd_random = 1'b0;
   logic [47:0] cmd_lba;
   logic [15:0] cmd_count = '0;
   logic        lba_take, busy, done, err;
   logic [7:0]  dev_status, dev_error;
   logic [7:0]  ud_count;
   logic [31:0] ud_data;
   logic        ud_rd, wb_full, wb_wr, wb_last, rb_empty, rb_last, rb_rd, rd_valid;
   logic [31:0] wb_data, rb_data, rd_data;

   always #5 clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0;
   logic [31:0] wb_log [0:4095];
   logic        wb_llog [0:4095];
   int          wb_n = 0, wb_seen = 0;
   logic [31:0] rd_log [0:4095];
   logic [31:0] rd_exp [0:4095];
   int          rd_n = 0, rd_sent = 0, rd_from = 0;
   logic [31:0] rb_mem [0:4095];
   logic        rb_lmem [0:4095];
   int          rb_wp = 0, rb_rp = 0;
   int          ud_prov = 0, ud_pop = 0, ud_exp = 0, take_k = 0;
   logic [47:0] lba_base_r = '0;
   logic        stall_en = 1'b0;

   assign rb_empty = (rb_wp == rb_rp);
   assign rb_data  = rb_mem[rb_rp];
   assign rb_last  = rb_lmem[rb_rp];
   assign ud_count = 8'(ud_prov - ud_pop);
   assign ud_data  = 32'hC0DE0000 + 32'(ud_pop);
   assign cmd_lba  = lba_base_r + 48'(take_k) * 48'h1111;
   assign wb_full  = stall_en && (cyc % 3 == 2);

   cmd_seq_fsm #(.SECT_DW(SD), .MAX_SECT(MS), .CW(16), .UCW(8)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_write(cmd_write),
      .cmd_random(cmd_random), .cmd_lba(cmd_lba), .cmd_count(cmd_count),
      .lba_take(lba_take), .busy(busy), .done(done), .err(err),
      .dev_status(dev_status), .dev_error(dev_error), .ud_count(ud_count),
      .ud_data(ud_data), .ud_rd(ud_rd), .wb_full(wb_full), .wb_wr(wb_wr),
      .wb_data(wb_data), .wb_last(wb_last), .rb_empty(rb_empty), .rb_data(rb_data),
      .rb_last(rb_last), .rb_rd(rb_rd), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (wb_wr) begin
         wb_log[wb_n]  <= wb_data;
         wb_llog[wb_n] <= wb_last;
         wb_n <= wb_n + 1;
      end
      if (rd_valid) begin
         rd_log[rd_n] <= rd_data;
         rd_n <= rd_n + 1;
      end
      if (rb_rd) rb_rp <= rb_rp + 1;
      if (ud_rd) ud_pop <= ud_pop + 1;
      if (cmd_start) take_k <= 0;
      else if (lba_take) take_k <= take_k + 1;
   end

   always @(negedge clk) begin
      if (cyc > 100000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog expired (all requirements): actual cycle %0d expected below 100000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic push(input logic [31:0] d, input bit l);
      rb_mem[rb_wp]  = d;
      rb_lmem[rb_wp] = l;
      rb_wp = rb_wp + 1;
   endtask

   task automatic wait_wb(input int n);
      while (wb_n < n) @(negedge clk);
   endtask

   task automatic start_req(input bit w, input bit r, input int cnt, input logic [47:0] lba);
      @(negedge clk);
      cmd_write = w; cmd_random = r; cmd_count = 16'(cnt); lba_base_r = lba;
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   // R2: register FIS layout
   task automatic expect_h2d(input bit w, input logic [47:0] lba, input int cnt);
      logic [31:0] e [0:4];
      e[0] = {8'h00, (w ? 8'h35 : 8'h25), 8'h80, 8'h27};
      e[1] = {8'h40, lba[23:0]};
      e[2] = {8'h00, lba[47:24]};
      e[3] = {16'h0, 16'(cnt)};
      e[4] = 32'h0;
      wait_wb(wb_seen + 5);
      for (int k = 0; k < 5; k++) begin
         chk(wb_log[wb_seen + k] == e[k], "R2 register FIS dword (R6 address/count)",
             64'(wb_log[wb_seen + k]), 64'(e[k]));
         chk(wb_llog[wb_seen + k] == (k == 4), "R2 register FIS last flag",
             64'(wb_llog[wb_seen + k]), 64'(k == 4));
      end
      wb_seen = wb_seen + 5;
   endtask

   // R4: one Data FIS per DMA Activate
   task automatic write_burst(input int ns);
      push(32'h00000039, 1'b1);
      wait_wb(wb_seen + 1 + ns * SD);
      chk(wb_log[wb_seen] == 32'h46 && !wb_llog[wb_seen], "R4 data FIS header",
          64'(wb_log[wb_seen]), 64'h46);
      for (int k = 0; k < ns * SD; k++) begin
         chk(wb_log[wb_seen + 1 + k] == 32'hC0DE0000 + 32'(ud_exp), "R4 payload dword",
             64'(wb_log[wb_seen + 1 + k]), 64'(32'hC0DE0000 + 32'(ud_exp)));
         chk(wb_llog[wb_seen + 1 + k] == (k == ns * SD - 1), "R4 payload last flag",
             64'(wb_llog[wb_seen + 1 + k]), 64'(k == ns * SD - 1));
         ud_exp = ud_exp + 1;
      end
      wb_seen = wb_seen + 1 + ns * SD;
   endtask

   task automatic send_d2h(input logic [7:0] s, input logic [7:0] e);
      push({e, s, 8'h00, 8'h34}, 1'b0);
      push(32'h0, 1'b0);
      push(32'h0, 1'b0);
      push(32'h0, 1'b0);
      push(32'h0, 1'b1);
   endtask

   task automatic send_data(input int ns);
      push(32'h00000046, 1'b0);
      for (int k = 0; k < ns * SD; k++) begin
         rd_exp[rd_sent] = 32'h5EED0000 + 32'(rd_sent);
         push(rd_exp[rd_sent], k == ns * SD - 1);
         rd_sent = rd_sent + 1;
      end
   endtask

   task automatic write_op(input int ns, input logic [47:0] lba);
      int rem;
      expect_h2d(1'b1, lba, ns);
      rem = ns;
      while (rem > 0) begin
         write_burst(rem > MS ? MS : rem);
         rem = rem - (rem > MS ? MS : rem);
      end
      send_d2h(8'h50, 8'h00);
   endtask

   task automatic read_op(input int ns, input logic [47:0] lba, input bit junk,
                          input logic [7:0] s, input logic [7:0] e);
      int rem;
      expect_h2d(1'b0, lba, ns);
      rem = ns;
      while (rem > 0) begin
         send_data(rem > MS ? MS : rem);
         rem = rem - (rem > MS ? MS : rem);
      end
      if (junk) begin   // R9: stray activate and unknown FIS type
         push(32'h00000039, 1'b1);
         push(32'h0000005F, 1'b0);
         push(32'h12345678, 1'b0);
         push(32'h9ABCDEF0, 1'b1);
      end
      send_d2h(s, e);
   endtask

   task automatic finish_chk(input bit ed, input bit ee, input string req);
      int t;
      t = 0;
      while (busy && t < 300) begin
         @(negedge clk);
         t = t + 1;
      end
      chk(!busy, req, 64'(busy), 64'(0));
      chk(done == ed, req, 64'(done), 64'(ed));
      chk(err == ee, req, 64'(err), 64'(ee));
   endtask

   task automatic check_rd();
      chk(rd_n == rd_sent, "R5 read dword count (R9 nothing extra)", 64'(rd_n), 64'(rd_sent));
      for (int i = rd_from; i < rd_sent; i++)
         chk(rd_log[i] == rd_exp[i], "R5 read payload order", 64'(rd_log[i]), 64'(rd_exp[i]));
      rd_from = rd_sent;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !err, "R1 reset flags", 64'({busy, done, err}), 64'(0));
      chk(!wb_wr && !rb_rd && !ud_rd && !rd_valid && !lba_take, "R1 reset strobes",
          64'({wb_wr, rb_rd, ud_rd, rd_valid, lba_take}), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !err, "R1 idle after reset", 64'({busy, done, err}), 64'(0));

      // R8: zero count
      start_req(1'b1, 1'b0, 0, 48'h0);
      chk(done && !busy && !err, "R8 zero count done", 64'({done, busy, err}), 64'(3'b100));
      repeat (5) @(negedge clk);
      chk(wb_n == wb_seen, "R8 no FIS for zero count", 64'(wb_n), 64'(wb_seen));

      // sequential sweep, R6 single command, R4/R5/R7/R9
      for (int w = 0; w < 2; w++) begin
         for (int c = 1; c <= 5; c++) begin
            logic [47:0] lba;
            lba = 48'hA1B2C3D4E5F6 + 48'(c * 977 + w * 31);
            stall_en = (c % 2 == 0);
            if (w == 1) begin
               ud_prov = ud_pop + c * SD;
               start_req(1'b1, 1'b0, c, lba);
               chk(busy && !done, "R10 busy and done cleared on accept",
                   64'({busy, done}), 64'(2'b10));
               write_op(c, lba);
               finish_chk(1'b1, 1'b0, "R7 sequential write done");
               chk(ud_pop == ud_exp, "R4 user buffer pops", 64'(ud_pop), 64'(ud_exp));
            end else begin
               start_req(1'b0, 1'b0, c, lba);
               read_op(c, lba, c[0], 8'h50, 8'h00);
               finish_chk(1'b1, 1'b0, "R7 sequential read done");
               check_rd();
            end
            chk(dev_status == 8'h50 && dev_error == 8'h00, "R7 status capture",
                64'({dev_status, dev_error}), 64'(16'h5000));
         end
      end
      stall_en = 1'b0;

      // R3 and R6: random write gated per command
      ud_prov = ud_pop + SD - 1;
      start_req(1'b1, 1'b1, 2, 48'h000100020003);
      repeat (15) @(negedge clk);
      chk(wb_n == wb_seen, "R3 no command with short buffer", 64'(wb_n), 64'(wb_seen));
      chk(busy, "R3 waiting while gated", 64'(busy), 64'(1));
      ud_prov = ud_prov + 1;
      write_op(1, 48'h000100020003);
      repeat (20) @(negedge clk);
      chk(wb_n == wb_seen, "R3 second random command gated", 64'(wb_n), 64'(wb_seen));
      ud_prov = ud_prov + SD;
      write_op(1, 48'h000100020003 + 48'h1111);
      finish_chk(1'b1, 1'b0, "R6 random write done");

      // R6: random read, three one-sector commands
      start_req(1'b0, 1'b1, 3, 48'hFFFF00000000);
      for (int k = 0; k < 3; k++)
         read_op(1, 48'hFFFF00000000 + 48'(k) * 48'h1111, k == 1, 8'h50, 8'h00);
      finish_chk(1'b1, 1'b0, "R6 random read done");
      check_rd();

      // R7: error on second of four random reads aborts the rest
      start_req(1'b0, 1'b1, 4, 48'h0000DEAD0000);
      read_op(1, 48'h0000DEAD0000, 1'b0, 8'h50, 8'h00);
      read_op(1, 48'h0000DEAD1111, 1'b0, 8'h51, 8'h04);
      finish_chk(1'b0, 1'b1, "R7 error flag");
      repeat (20) @(negedge clk);
      chk(wb_n == wb_seen, "R7 remaining commands dropped", 64'(wb_n), 64'(wb_seen));
      chk(dev_status == 8'h51 && dev_error == 8'h04, "R7 error status capture",
          64'({dev_status, dev_error}), 64'(16'h5104));
      check_rd();

      // R10: start while busy is ignored
      start_req(1'b0, 1'b0, 1, 48'h111122223333);
      chk(!err, "R10 err cleared on accept", 64'(err), 64'(0));
      expect_h2d(1'b0, 48'h111122223333, 1);
      start_req(1'b1, 1'b0, 3, 48'h444455556666);
      send_data(1);
      send_d2h(8'h50, 8'h00);
      finish_chk(1'b1, 1'b0, "R10 first request completes");
      repeat (20) @(negedge clk);
      chk(wb_n == wb_seen, "R10 ignored start wrote nothing", 64'(wb_n), 64'(wb_seen));
      chk(ud_pop == ud_exp, "R10 no user pops from ignored start", 64'(ud_pop), 64'(ud_exp));
      check_rd();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule